// File: doc/BRIEF.md
# Host-Side Radio Power Sequencer

This block sits in a host controller and turns a wireless module on and off in a safe order. One request input, `powerReq`, starts the sequence. The block then drives four module controls. It raises the battery-rail enable first, then the I/O-rail load-switch enable, then chip-enable. Last, after a crystal-settling interval, it releases the active-low module reset. Each wait is counted on the known system clock. The reset-release delay is computed from the clock frequency and a settle time in milliseconds.

Dropping `powerReq` brings the module down in the reverse order. Reset and chip-enable fall together, then the I/O rail falls, then the battery rail. Dropping the request in the middle of power-up abandons the power-up at once. The block then runs the same full power-down from the point it had reached. A new request that arrives during power-down waits until the module is fully off.

A set of host interface pads passes through the block. Whenever chip-enable is low, each pad is held at a driven-low data value with its output enable off. This keeps the unpowered module from being back-powered through its pins. Two status outputs report when the module is usable (`ready`) and when every rail is removed (`off`).

Top module: `pwr_seq_top`

## Requirements
- R1: `ioEn` is never high while `batEn` is low. On power-up, `ioEn` rises exactly BAT_WAIT cycles after `batEn` rises. `batEn` rises on the first clock edge that samples `powerReq` high while the block is fully off.
- R2: `chipEn` is never high while `ioEn` is low. On power-up, `chipEn` rises exactly IO_WAIT cycles after `ioEn` rises.
- R3: `modRstN` rises exactly RST_CYC = (CLK_HZ/1000)*RST_MS cycles after `chipEn` rises, and is high only while `chipEn` is high.
- R4: On power-down, `chipEn` and `modRstN` fall on the same clock edge. That edge is the first one that samples `powerReq` low. `ioEn` falls exactly DN_WAIT cycles later.
- R5: `batEn` falls exactly DN_WAIT cycles after the edge on which `ioEn` falls, or would have fallen. `batEn` is the last control to fall.
- R6: While `chipEn` is low, every bit of `padOut` and `padOe` is 0 (driven low, output disabled). While `chipEn` is high, `padOut` equals `hostPadOut` and `padOe` equals `hostPadOe`.
- R7: `ready` is high exactly when `modRstN` is high. `off` is high exactly when `batEn`, `ioEn` and `chipEn` are all low.
- R8: If `powerReq` is sampled low at edge d during power-up, nothing further rises at or after edge d. Any of `chipEn` and `modRstN` that are high fall at edge d. `ioEn`, if high, falls at d+DN_WAIT. `batEn` falls at d+2*DN_WAIT.
- R9: `powerReq` sampled high during power-down has no effect until `batEn` has fallen. `batEn` then rises again on the next edge.
- R10: During and right after reset, `batEn`, `ioEn`, `chipEn`, `modRstN`, `ready`, `padOut` and `padOe` are 0, and `off` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rstN | input | 1 | Active-low asynchronous reset of the sequencer |
| powerReq | input | 1 | High requests module power, low requests power-down |
| hostPadOut | input | PADS | Host data values for the module interface pads |
| hostPadOe | input | PADS | Host output enables for the module interface pads |
| batEn | output | 1 | Battery-rail enable |
| ioEn | output | 1 | I/O-rail load-switch enable |
| chipEn | output | 1 | Module chip-enable, always driven |
| modRstN | output | 1 | Module active-low reset, always driven |
| padOut | output | PADS | Gated pad data toward the module |
| padOe | output | PADS | Gated pad output enables toward the module |
| ready | output | 1 | Module is out of reset and usable |
| off | output | 1 | All module rails are removed |

## Verification
The bench drops `powerReq` at chosen and random points in the power-up sequence. The directed points are one cycle before and at each rise edge. At each point it checks which controls rose and the exact edge at which each one falls.

A design that handled an abort wrongly would show a late rise after the drop, would skip the I/O wait, or would drop the battery rail too early. An off-by-one timer would show up as a rise or fall edge shifted by one cycle.

A request re-raised during power-down must neither restart the sequence early nor be lost. A pad gate keyed on the wrong enable would let a pad drive high while chip-enable is low.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_OFF,
    SEQ_BAT,
    SEQ_IO,
    SEQ_CLK,
    SEQ_ON,
    SEQ_DNCHIP,
    SEQ_DNIO
  } seqState_t;

  typedef enum logic [1:0] {
    WAIT_BAT,
    WAIT_IO,
    WAIT_CLK,
    WAIT_DN
  } waitSel_t;

  typedef struct packed {
    logic     batOn;
    logic     ioOn;
    logic     chipOn;
    logic     rstRelease;
    logic     chipRstOff;
    logic     ioOff;
    logic     batOff;
    logic     load;
    waitSel_t sel;
  } seqStrobe_t;

endpackage

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerReq,
  input  logic       timerDone,
  output seqStrobe_t strobe
);

  seqState_t seqState, seqNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqState <= SEQ_OFF;
    else       seqState <= seqNext;
  end

  always_comb begin
    seqNext = seqState;
    strobe  = '0;
    strobe.sel = WAIT_BAT;
    unique case (seqState)
      SEQ_OFF: begin
        if (powerReq) begin
          strobe.batOn = 1'b1;
          strobe.load  = 1'b1;
          strobe.sel   = WAIT_BAT;
          seqNext      = SEQ_BAT;
        end
      end
      SEQ_BAT, SEQ_IO, SEQ_CLK, SEQ_ON: begin
        if (!powerReq) begin
          strobe.chipRstOff = 1'b1;
          strobe.load       = 1'b1;
          strobe.sel        = WAIT_DN;
          seqNext           = SEQ_DNCHIP;
        end else if (timerDone) begin
          if (seqState == SEQ_BAT) begin
            strobe.ioOn = 1'b1;
            strobe.load = 1'b1;
            strobe.sel  = WAIT_IO;
            seqNext     = SEQ_IO;
          end else if (seqState == SEQ_IO) begin
            strobe.chipOn = 1'b1;
            strobe.load   = 1'b1;
            strobe.sel    = WAIT_CLK;
            seqNext       = SEQ_CLK;
          end else if (seqState == SEQ_CLK) begin
            strobe.rstRelease = 1'b1;
            seqNext           = SEQ_ON;
          end
        end
      end
      SEQ_DNCHIP: begin
        if (timerDone) begin
          strobe.ioOff = 1'b1;
          strobe.load  = 1'b1;
          strobe.sel   = WAIT_DN;
          seqNext      = SEQ_DNIO;
        end
      end
      SEQ_DNIO: begin
        if (timerDone) begin
          strobe.batOff = 1'b1;
          seqNext       = SEQ_OFF;
        end
      end
      default: seqNext = SEQ_OFF;
    endcase
  end

  AST_DOWN_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    ((seqState == SEQ_DNCHIP) || (seqState == SEQ_DNIO)) |=> (seqState != SEQ_BAT)); // R9

endmodule

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int BAT_WAIT = 4,
  parameter int IO_WAIT  = 6,
  parameter int DN_WAIT  = 3,
  parameter int RST_CYC  = 250000,
  parameter int PADS     = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strobe,
  input  logic [PADS-1:0] hostPadOut,
  input  logic [PADS-1:0] hostPadOe,
  output logic            timerDone,
  output logic            batEn,
  output logic            ioEn,
  output logic            chipEn,
  output logic            modRstN,
  output logic [PADS-1:0] padOut,
  output logic [PADS-1:0] padOe,
  output logic            ready,
  output logic            off
);

  localparam int M1   = (BAT_WAIT > IO_WAIT) ? BAT_WAIT : IO_WAIT;
  localparam int M2   = (DN_WAIT > RST_CYC) ? DN_WAIT : RST_CYC;
  localparam int MAXW = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXW + 1);

  logic [TW-1:0] timer, loadVal;

  always_comb begin
    unique case (strobe.sel)
      WAIT_BAT: loadVal = TW'(BAT_WAIT - 1);
      WAIT_IO:  loadVal = TW'(IO_WAIT - 1);
      WAIT_CLK: loadVal = TW'(RST_CYC - 1);
      default:  loadVal = TW'(DN_WAIT - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timer <= '0;
    else if (strobe.load)     timer <= loadVal;
    else if (timer != '0)     timer <= timer - TW'(1);
  end

  assign timerDone = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      batEn   <= 1'b0;
      ioEn    <= 1'b0;
      chipEn  <= 1'b0;
      modRstN <= 1'b0;
    end else begin
      if (strobe.batOn)      batEn   <= 1'b1;
      if (strobe.batOff)     batEn   <= 1'b0;
      if (strobe.ioOn)       ioEn    <= 1'b1;
      if (strobe.ioOff)      ioEn    <= 1'b0;
      if (strobe.chipOn)     chipEn  <= 1'b1;
      if (strobe.rstRelease) modRstN <= 1'b1;
      if (strobe.chipRstOff) begin
        chipEn  <= 1'b0;
        modRstN <= 1'b0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < PADS; g++) begin : gPadGate
      assign padOut[g] = chipEn & hostPadOut[g];
      assign padOe[g]  = chipEn & hostPadOe[g];
    end
  endgenerate

  assign ready = modRstN;
  assign off   = ~(batEn | ioEn | chipEn);

  // cycles chip-enable has been high, saturating, for the reset-delay check
  logic [TW-1:0] chipAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           chipAge <= '0;
    else if (!chipEn)                    chipAge <= '0;
    else if (chipAge < TW'(RST_CYC))     chipAge <= chipAge + TW'(1);
  end

  AST_IO_NEEDS_BAT: assert property (@(posedge clk) disable iff (!rstN)
    ioEn |-> batEn); // R1
  AST_CHIP_NEEDS_IO: assert property (@(posedge clk) disable iff (!rstN)
    chipEn |-> ioEn); // R2
  AST_RST_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modRstN) |-> (chipAge >= TW'(RST_CYC))); // R3
  AST_RST_NEEDS_CHIP: assert property (@(posedge clk) disable iff (!rstN)
    modRstN |-> chipEn); // R3
  AST_CHIP_RST_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chipEn) |-> !modRstN); // R4
  AST_BAT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(batEn) |-> (!ioEn && !chipEn)); // R5

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int CLK_HZ   = 50000000,
  parameter int RST_MS   = 5,
  parameter int BAT_WAIT = 4,
  parameter int IO_WAIT  = 6,
  parameter int DN_WAIT  = 3,
  parameter int PADS     = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            powerReq,
  input  logic [PADS-1:0] hostPadOut,
  input  logic [PADS-1:0] hostPadOe,
  output logic            batEn,
  output logic            ioEn,
  output logic            chipEn,
  output logic            modRstN,
  output logic [PADS-1:0] padOut,
  output logic [PADS-1:0] padOe,
  output logic            ready,
  output logic            off
);

  localparam int RST_CYC = (CLK_HZ / 1000) * RST_MS;

  seqStrobe_t strobe;
  logic       timerDone;

  pwr_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .powerReq  (powerReq),
    .timerDone (timerDone),
    .strobe    (strobe)
  );

  pwr_seq_dp #(
    .BAT_WAIT (BAT_WAIT),
    .IO_WAIT  (IO_WAIT),
    .DN_WAIT  (DN_WAIT),
    .RST_CYC  (RST_CYC),
    .PADS     (PADS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostPadOut (hostPadOut),
    .hostPadOe  (hostPadOe),
    .timerDone  (timerDone),
    .batEn      (batEn),
    .ioEn       (ioEn),
    .chipEn     (chipEn),
    .modRstN    (modRstN),
    .padOut     (padOut),
    .padOe      (padOe),
    .ready      (ready),
    .off        (off)
  );

endmodule

// File: tb/tb_pwr_seq_top.sv
module tb_pwr_seq_top;

  localparam int CLK_HZ = 20000;
  localparam int RST_MS = 5;
  localparam int B      = 4;
  localparam int I      = 6;
  localparam int D      = 3;
  localparam int PADS   = 4;
  localparam int C      = (CLK_HZ / 1000) * RST_MS;
  localparam int LIMIT  = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerReq = 1'b0;
  logic [PADS-1:0] hostPadOut = '0;
  logic [PADS-1:0] hostPadOe = '0;
  logic batEn, ioEn, chipEn, modRstN, ready, off;
  logic [PADS-1:0] padOut, padOe;

  pwr_seq_top #(
    .CLK_HZ(CLK_HZ), .RST_MS(RST_MS), .BAT_WAIT(B), .IO_WAIT(I),
    .DN_WAIT(D), .PADS(PADS)
  ) dut (
    .clk(clk), .rstN(rstN), .powerReq(powerReq),
    .hostPadOut(hostPadOut), .hostPadOe(hostPadOe),
    .batEn(batEn), .ioEn(ioEn), .chipEn(chipEn), .modRstN(modRstN),
    .padOut(padOut), .padOe(padOe), .ready(ready), .off(off)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int nTests = 0;
  int nFail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // event log: index 0 bat, 1 io, 2 chip, 3 reset
  int riseAt[4];
  int fallAt[4];
  int offRiseAt;
  logic [3:0] prevSig = '0;
  logic prevOff = 1'b1;
  int flagOrder = 0;
  int flagPad = 0;
  int flagStat = 0;

  always @(negedge clk) begin
    logic [3:0] s;
    s = {modRstN, chipEn, ioEn, batEn};
    if (rstN) begin
      for (int k = 0; k < 4; k++) begin
        if (s[k] && !prevSig[k]) riseAt[k] = cyc;
        if (!s[k] && prevSig[k]) fallAt[k] = cyc;
      end
      if (off && !prevOff) offRiseAt = cyc;
      if ((ioEn && !batEn) || (chipEn && !ioEn)) flagOrder++;
      if (chipEn ? (padOut != hostPadOut || padOe != hostPadOe)
                 : (padOut != '0 || padOe != '0)) flagPad++;
      if (ready != modRstN || off != !(batEn || ioEn || chipEn)) flagStat++;
    end
    prevSig = s;
    prevOff = off;
    hostPadOut = PADS'($urandom);
    hostPadOe  = PADS'($urandom);
  end

  task automatic check(string tag, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic clearLog();
    for (int k = 0; k < 4; k++) begin
      riseAt[k] = -1;
      fallAt[k] = -1;
    end
    offRiseAt = -1;
  endtask

  function automatic int riseOff(int k);
    case (k)
      0: return 1;
      1: return 1 + B;
      2: return 1 + B + I;
      default: return 1 + B + I + C;
    endcase
  endfunction

  function automatic int expRise(int r, int d, int k);
    return (r + riseOff(k) <= d) ? r + riseOff(k) : -1;
  endfunction

  function automatic int expFall(int r, int d, int k);
    if (k == 0) return d + 1 + 2 * D;
    if (expRise(r, d, k) < 0) return -1;
    if (k == 1) return d + 1 + D;
    return d + 1;
  endfunction

  // raise powerReq, drop it after hold cycles, check the full event log
  task automatic scenario(int hold);
    int r, d;
    string tg;
    clearLog();
    flagOrder = 0; flagPad = 0; flagStat = 0;
    @(negedge clk);
    powerReq = 1'b1;
    r = cyc;
    waitCyc(r + hold);
    powerReq = 1'b0;
    d = cyc;
    waitCyc(d + 2 * D + 4);
    tg = (hold > B + I + C) ? "R4" : "R8";
    check("R1 bat rise", riseAt[0], expRise(r, d, 0));
    check("R1 io rise", riseAt[1], expRise(r, d, 1));
    check("R2 chip rise", riseAt[2], expRise(r, d, 2));
    check("R3 reset rise", riseAt[3], expRise(r, d, 3));
    check({tg, " chip fall"}, fallAt[2], expFall(r, d, 2));
    check({tg, " reset fall"}, fallAt[3], expFall(r, d, 3));
    check({tg, " io fall"}, fallAt[1], expFall(r, d, 1));
    check("R5 bat fall", fallAt[0], expFall(r, d, 0));
    check("R7 off rise", offRiseAt, expFall(r, d, 0));
    check("R2 order", flagOrder, 0);
    check("R6 pad gate", flagPad, 0);
    check("R7 status", flagStat, 0);
  endtask

  initial begin : watchdog
    wait (cyc > LIMIT);
    nFail++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, LIMIT);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    int seedV, r, d;
    seedV = $urandom(32'h5eed);
    clearLog();
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 batEn", batEn, 0);
    check("R10 chipEn", chipEn, 0);
    check("R10 modRstN", modRstN, 0);
    check("R10 ready", ready, 0);
    check("R10 off", off, 1);
    check("R10 pads", int'(padOut | padOe), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 after reset io", ioEn, 0);
    check("R10 after reset off", off, 1);

    // directed abort points around each rise edge, then a full cycle
    scenario(1);
    scenario(B);
    scenario(B + 1);
    scenario(B + I);
    scenario(B + I + 1);
    scenario(B + I + C);
    scenario(B + I + C + 1);
    scenario(B + I + C + 20);

    // random abort points
    for (int n = 0; n < 10; n++) scenario($urandom_range(1, B + I + C + 10));

    // R9: request re-raised during power-down
    clearLog();
    @(negedge clk);
    powerReq = 1'b1;
    r = cyc;
    waitCyc(r + B + 2);
    powerReq = 1'b0;
    d = cyc;
    @(negedge clk);
    powerReq = 1'b1;
    waitCyc(d + 2 * D + 4);
    check("R9 io fall", fallAt[1], d + 1 + D);
    check("R9 bat fall", fallAt[0], d + 1 + 2 * D);
    check("R9 bat re-rise", riseAt[0], d + 2 + 2 * D);
    waitCyc(d + 2 * D + 6 + B + I + C);
    check("R9 reset rise", riseAt[3], d + 2 + 2 * D + B + I + C);
    check("R7 ready", ready, 1);
    check("R6 pad pass", int'(padOut == hostPadOut && padOe == hostPadOe), 1);
    @(negedge clk);
    powerReq = 1'b0;
    d = cyc;
    waitCyc(d + 2 * D + 4);
    check("R4 chip fall", fallAt[2], d + 1);
    check("R5 final off", off, 1);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule